// File: doc/BRIEF.md
# Aperture Address Remapper

This block sits on the address path of one bus master in front of several target ports. The master's 32-bit address space is cut into 16 equal windows of 256 MB, picked by the top four address bits. For each window, a table entry names the target port that serves it. A second entry gives a new value for those top four bits, so a window can land on any 256 MB region inside its target. The translate path is purely combinational: it returns a port code and the rewritten address in the same cycle as the request. Windows with no target raise a decode-error flag.

Software fills the tables through a small 32-bit register port. Writes go to a shadow copy. Translation keeps using the live copy until software writes a commit command, and then the whole shadow copy moves into the live copy at one clock edge. Reset clears both copies, so nothing is reachable until software programs the tables and commits them.

Top module: `aperture_remap`

## Requirements
- R1: The window index of a request is `in_addr[31:28]`. Every window uses its own table entry.
- R2: `out_addr` equals the live offset code of the window in bits [31:28], followed by `in_addr[27:0]` unchanged.
- R3: While `in_valid` is 1 and the live port code of the window is nonzero, `slv_sel` carries that code and `dec_err` is 0.
- R4: Port code 0 means the window is unmapped. While `in_valid` is 1 for such a window, `dec_err` is 1 and `slv_sel` is 0. While `in_valid` is 0, both outputs are 0.
- R5: Shadow port codes for windows 0 to 7 are written at byte offset 0x0 and those for windows 8 to 15 at 0x4. Shadow offset codes for windows 0 to 7 are written at 0x8 and those for windows 8 to 15 at 0xC. Window i uses bits [4(i mod 8)+3 : 4(i mod 8)] of its register.
- R6: A shadow write has no effect on translation until a commit.
- R7: A commit is a write to byte offset 0x10 with data bit 0 set. A write to 0x10 with bit 0 clear does nothing.
- R8: On a commit, all four shadow registers become live at the same clock edge. In the cycle of the commit write, translation still uses the old live table, and from the next cycle it uses the new one.
- R9: After reset, the shadow and live tables are all zero and every window is unmapped.
- R10: Reads at 0x0 to 0xC return the shadow values. Reads at 0x10 and at any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wen | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| in_valid | input | 1 | Master request valid |
| in_addr | input | 32 | Master address |
| slv_sel | output | 4 | Target port code, 0 when none |
| out_addr | output | 32 | Translated address |
| dec_err | output | 1 | Request hit an unmapped window |

## Verification
A commit write and a live translation can fall in the same cycle. In that cycle the translate path must still show the old table, with the new table appearing only after the edge. The bench provokes this by holding a request on one window while it issues the commit write. It samples the outputs before the edge, expecting the old mapping or a decode error, and again one cycle later, expecting the new mapping. The bench also keeps a request steady across shadow-only writes and checks that the outputs do not move.

// File: rtl/ar_pkg.sv
package ar_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // commit command carried in bit 0 of the write data
    function automatic logic is_commit(input word_t w);
        return w[0];
    endfunction
endpackage

// File: rtl/ar_table_regs.sv
module ar_table_regs
    import ar_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int CFG_AW = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_wen,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  word_t                        cfg_wdata,
    output word_t                        cfg_rdata,
    output logic [NREG-1:0][WORD_W-1:0]  live_sel,
    output logic [NREG-1:0][WORD_W-1:0]  live_off
);
    localparam int WIX_W = CFG_AW - 2;
    localparam int COMMIT_IX = 2 * NREG;

    typedef struct packed {
        logic [NREG-1:0][WORD_W-1:0] sh_sel;
        logic [NREG-1:0][WORD_W-1:0] sh_off;
        logic [NREG-1:0][WORD_W-1:0] lv_sel;
        logic [NREG-1:0][WORD_W-1:0] lv_off;
    } tbl_t;

    tbl_t st_d, st_q;
    logic [WIX_W-1:0] widx;

    assign widx = cfg_addr[CFG_AW-1:2];

    always_comb begin
        st_d      = st_q;
        cfg_rdata = '0;
        for (int k = 0; k < NREG; k++) begin
            if (widx == WIX_W'(k)) begin
                cfg_rdata = st_q.sh_sel[k];
                if (cfg_wen) st_d.sh_sel[k] = cfg_wdata;
            end
            if (widx == WIX_W'(NREG + k)) begin
                cfg_rdata = st_q.sh_off[k];
                if (cfg_wen) st_d.sh_off[k] = cfg_wdata;
            end
        end
        if (cfg_wen && widx == WIX_W'(COMMIT_IX) && is_commit(cfg_wdata)) begin
            st_d.lv_sel = st_q.sh_sel;
            st_d.lv_off = st_q.sh_off;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_sel = st_q.lv_sel;
    assign live_off = st_q.lv_off;
endmodule

// File: rtl/ar_xlate.sv
module ar_xlate #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 4
) (
    input  logic                                  in_valid,
    input  logic [ADDR_W-1:0]                     in_addr,
    input  logic [(2**FIELD_W)-1:0][FIELD_W-1:0]  sel_tab,
    input  logic [(2**FIELD_W)-1:0][FIELD_W-1:0]  off_tab,
    output logic [FIELD_W-1:0]                    slv_sel,
    output logic [ADDR_W-1:0]                     out_addr,
    output logic                                  dec_err
);
    logic [FIELD_W-1:0] win;
    logic [FIELD_W-1:0] code;

    always_comb begin
        win      = in_addr[ADDR_W-1 -: FIELD_W];
        code     = sel_tab[win];
        out_addr = {off_tab[win], in_addr[ADDR_W-FIELD_W-1:0]};
        dec_err  = in_valid && (code == '0);
        slv_sel  = in_valid ? code : '0;
    end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
    import ar_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 4,
    parameter int CFG_AW  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wen,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic [31:0]        cfg_rdata,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    output logic [FIELD_W-1:0] slv_sel,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               dec_err
);
    localparam int NUM_WIN = 2 ** FIELD_W;
    localparam int NREG    = NUM_WIN * FIELD_W / WORD_W;

    logic [NREG-1:0][WORD_W-1:0]      live_sel, live_off;
    logic [NUM_WIN-1:0][FIELD_W-1:0]  sel_tab, off_tab;

    assign sel_tab = live_sel;
    assign off_tab = live_off;

    ar_table_regs #(.NREG(NREG), .CFG_AW(CFG_AW)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wen  (cfg_wen),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .live_sel (live_sel),
        .live_off (live_off)
    );

    ar_xlate #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) i_xlate (
        .in_valid(in_valid),
        .in_addr (in_addr),
        .sel_tab (sel_tab),
        .off_tab (off_tab),
        .slv_sel (slv_sel),
        .out_addr(out_addr),
        .dec_err (dec_err)
    );
endmodule

// File: rtl/ar_checker.sv
module ar_checker #(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 4,
    parameter int CFG_AW  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_wen,
    input logic [CFG_AW-1:0]  cfg_addr,
    input logic [31:0]        cfg_wdata,
    input logic [31:0]        cfg_rdata,
    input logic               in_valid,
    input logic [ADDR_W-1:0]  in_addr,
    input logic [FIELD_W-1:0] slv_sel,
    input logic [ADDR_W-1:0]  out_addr,
    input logic               dec_err
);
    localparam logic [CFG_AW-1:0] COMMIT_ADDR = CFG_AW'(16);

    logic commit_wr;
    assign commit_wr = cfg_wen && (cfg_addr == COMMIT_ADDR) && cfg_wdata[0];

    // R4: an error never comes without a request
    a_r4_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> in_valid);

    // R4: an error never drives a port code
    a_r4_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> (slv_sel == '0));

    // R6: without a commit, a steady request gives steady outputs
    a_r6_hold_table: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(commit_wr) && $stable(in_addr) && $stable(in_valid))
            |-> ($stable(slv_sel) && $stable(out_addr) && $stable(dec_err)));

    // R9: first cycle out of reset every window is unmapped
    a_r9_reset_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && in_valid) |-> dec_err);

    // R10: the commit register reads as zero
    a_r10_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == COMMIT_ADDR) |-> (cfg_rdata == '0));
endmodule

bind aperture_remap ar_checker #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .CFG_AW(CFG_AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wen  (cfg_wen),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .in_valid (in_valid),
    .in_addr  (in_addr),
    .slv_sel  (slv_sel),
    .out_addr (out_addr),
    .dec_err  (dec_err)
);

// File: tb/test_aperture_remap.sv
module test_aperture_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wen = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic [3:0]  slv_sel;
    logic [31:0] out_addr;
    logic        dec_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [3:0] sh_sel [16];
    logic [3:0] sh_off [16];
    logic [3:0] lv_sel [16];
    logic [3:0] lv_off [16];

    always #5 clk = ~clk;

    aperture_remap i_aperture_remap (
        .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_addr(in_addr), .slv_sel(slv_sel), .out_addr(out_addr), .dec_err(dec_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wen = 1'b0;
    endtask

    function automatic logic [31:0] pack(input logic [3:0] t [16], input int base);
        logic [31:0] w = '0;
        for (int j = 0; j < 8; j++) w[4*j +: 4] = t[base + j];
        return w;
    endfunction

    task automatic write_shadow();
        wr(5'h00, pack(sh_sel, 0));
        wr(5'h04, pack(sh_sel, 8));
        wr(5'h08, pack(sh_off, 0));
        wr(5'h0C, pack(sh_off, 8));
    endtask

    task automatic read_check(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = a;
        #2 chk(req, cfg_rdata, exp);
    endtask

    task automatic commit();
        wr(5'h10, 32'h1);
        for (int i = 0; i < 16; i++) begin lv_sel[i] = sh_sel[i]; lv_off[i] = sh_off[i]; end
    endtask

    // expected outputs for the current live model, one request
    task automatic check_req(input logic v, input logic [31:0] a, input string req);
        int w;
        w = int'(a[31:28]);
        in_valid = v; in_addr = a;
        #2;
        chk({req, " out_addr"}, out_addr, {lv_off[w], a[27:0]});
        if (!v) begin
            chk({req, " idle sel"}, {28'd0, slv_sel}, 32'd0);
            chk({req, " idle err"}, {31'd0, dec_err}, 32'd0);
        end else if (lv_sel[w] == 4'd0) begin
            chk({req, " R4 err"}, {31'd0, dec_err}, 32'd1);
            chk({req, " R4 sel"}, {28'd0, slv_sel}, 32'd0);
        end else begin
            chk({req, " R3 sel"}, {28'd0, slv_sel}, {28'd0, lv_sel[w]});
            chk({req, " R3 err"}, {31'd0, dec_err}, 32'd0);
        end
    endtask

    task automatic sweep(input string req);
        logic [27:0] lows [3];
        lows[0] = 28'h0000000; lows[1] = 28'h0ABCDEF; lows[2] = 28'hFFFFFFF;
        for (int w = 0; w < 16; w++)
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check_req(1'b1, {w[3:0], lows[k]}, req);
            end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin sh_sel[i] = 0; sh_off[i] = 0; lv_sel[i] = 0; lv_off[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 5; a++) read_check(5'(a * 4), 32'd0, "R9 reset read");
        sweep("R9 reset");

        // pattern A into shadow; window 9 stays unmapped
        for (int i = 0; i < 16; i++) begin
            sh_sel[i] = 4'((i * 5 + 3) % 16);
            sh_off[i] = 4'(15 - i);
        end
        write_shadow();
        read_check(5'h00, pack(sh_sel, 0), "R5 R10 sel lo");
        read_check(5'h04, pack(sh_sel, 8), "R5 R10 sel hi");
        read_check(5'h08, pack(sh_off, 0), "R5 R10 off lo");
        read_check(5'h0C, pack(sh_off, 8), "R5 R10 off hi");
        read_check(5'h10, 32'd0, "R10 commit reg");
        read_check(5'h14, 32'd0, "R10 unused");
        sweep("R6 no commit");

        // R7: commit register with bit 0 clear
        wr(5'h10, 32'hFFFF_FFFE);
        sweep("R7 ignored commit");

        // R8: commit and request in the same cycle
        @(negedge clk);
        cfg_wen = 1'b1; cfg_addr = 5'h10; cfg_wdata = 32'h1;
        check_req(1'b1, 32'h3123_4567, "R8 old table");
        @(negedge clk);
        cfg_wen = 1'b0;
        for (int i = 0; i < 16; i++) begin lv_sel[i] = sh_sel[i]; lv_off[i] = sh_off[i]; end
        check_req(1'b1, 32'h3123_4567, "R8 new table");
        @(negedge clk);
        check_req(1'b0, 32'h5000_0010, "R4 idle");
        sweep("R1 R2 R3 R4 pattern A");

        // pattern B: partial shadow update then commit
        for (int i = 0; i < 16; i++) begin
            sh_sel[i] = 4'(i % 3);
            sh_off[i] = 4'((i * 7) % 16);
        end
        wr(5'h00, pack(sh_sel, 0));
        wr(5'h0C, pack(sh_off, 8));
        sweep("R6 partial shadow");
        write_shadow();
        read_check(5'h04, pack(sh_sel, 8), "R10 pattern B");
        commit();
        sweep("R1 R2 R3 R4 pattern B");

        // reset again mid-run clears both tables
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 16; i++) begin sh_sel[i] = 0; sh_off[i] = 0; lv_sel[i] = 0; lv_off[i] = 0; end
        @(negedge clk);
        rst_n = 1'b1;
        read_check(5'h08, 32'd0, "R9 second reset");
        sweep("R9 second reset");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule